// File: doc/BRIEF.md
# Data Link Transmit Interrupt Controller

This block starts a repeated bit-oriented message on a framer's data link channel and produces the interrupt status for that transfer. A processor port writes a repeat count. It then writes the control register with the packet-mode bit at 0, which starts the transfer. On start the block latches the count, flags the start of the transfer and gives a one-cycle start pulse to the message serialiser. It counts the serialiser's per-message done pulses. When the last repetition is done it flags the end of the transfer and returns to idle.

Each status bit has its own enable. A block-wide enable sits above the per-bit enables. The interrupt line is a level output, active high. A mode bit selects how status clears. In clear-on-read mode, a read of the status register clears it. In write-clear mode, the processor writes a 1 to each bit it wants to clear.

Top module: `dlk_txirq_ctrl`

Register offsets on `cpu_addr`:
- 0: control. Bit 0 is the packet-mode bit.
- 1: repeat count.
- 2: per-bit enables. Bit 6 enables start-of-transfer, bit 4 enables end-of-transfer.
- 3: block enable, at bit 3.
- 4: clear mode, at bit 0.
- 5: status. Bit 6 is start-of-transfer, bit 4 is end-of-transfer.

## Requirements
- R1: After reset, every register reads 0, `irq` is 0 and `tx_busy` is 0.
- R2: A write to offset 0 with bit 0 at 0 while idle starts a transfer. On the next cycle `tx_busy` is 1 and status bit 6 is 1. `tx_start` is high for exactly the cycle of the write. A control write with bit 0 at 1 starts nothing.
- R3: The count at offset 1 is latched at start, and a count of 0 means one message. Status bit 4 is set and `tx_busy` drops on the clock edge that takes the done pulse completing the latched count. Writes to offset 1 during a transfer do not change that count.
- R4: `msg_done` pulses while idle have no effect on status or on `tx_busy`.
- R5: A start write while busy is ignored. It sets no status and does not restart the count.
- R6: `irq` = offset3[3] AND ((status[6] AND offset2[6]) OR (status[4] AND offset2[4])).
- R7: While offset 3 bit 3 is 0, `irq` stays 0 whatever the status and the per-bit enables.
- R8: With offset 4 bit 0 at 1 (clear-on-read), a read of offset 5 returns the current status and then clears it. Writes to offset 5 have no effect in this mode.
- R9: With offset 4 bit 0 at 0 (write-clear), reads do not clear status. A write to offset 5 clears each status bit written as 1 and leaves each bit written as 0.
- R10: If a start or end event lands in the same cycle as a clearing read or write of that bit, the bit ends up set.
- R11: Offsets 1 to 4 read back what was written, masked to their defined bits. Offset 0 reads back bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe; a clearing read takes effect at the clock edge |
| cpu_addr | input | 3 | Register offset |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, combinational from `cpu_addr` |
| msg_done | input | 1 | One pulse per message sent by the serialiser |
| tx_start | output | 1 | Pulse when a transfer is accepted |
| tx_busy | output | 1 | A transfer is in progress |
| irq | output | 1 | Level interrupt, active high |

## Verification
The hardest case to reach is a clear that collides with an event. It needs a clear-on-read status read, or a write-one-to-clear, in the same cycle as the done pulse that completes the count. The bench drives the read strobe and `msg_done` together in one cycle. It then checks that bit 4 survives while the read still returns the value from before the clear. A second collision pairs a start write with a clearing read, which cannot be done on one bus. The bench instead checks that a start refused while busy leaves status clear and leaves the end-of-transfer timing unchanged.

// File: rtl/dlk_txirq_pkg.sv
package dlk_txirq_pkg;

    localparam int DW = 8;
    localparam int AW = 3;

    localparam int SOT_BIT = 6;
    localparam int EOT_BIT = 4;
    localparam int BEN_BIT = 3;
    localparam int PKT_BIT = 0;
    localparam int COR_BIT = 0;

    typedef enum logic [AW-1:0] {
        OFS_CTRL   = 3'd0,
        OFS_REPEAT = 3'd1,
        OFS_IEN    = 3'd2,
        OFS_BEN    = 3'd3,
        OFS_CMODE  = 3'd4,
        OFS_STS    = 3'd5
    } reg_ofs_e;

    typedef struct packed {
        logic sot;
        logic eot;
    } evt_t;

    function automatic logic [DW-1:0] pack_pair(input evt_t v);
        logic [DW-1:0] r;
        r = '0;
        r[SOT_BIT] = v.sot;
        r[EOT_BIT] = v.eot;
        return r;
    endfunction

    function automatic evt_t unpack_pair(input logic [DW-1:0] d);
        evt_t v;
        v.sot = d[SOT_BIT];
        v.eot = d[EOT_BIT];
        return v;
    endfunction

endpackage

// File: rtl/dlk_txirq_regs.sv
module dlk_txirq_regs
    import dlk_txirq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cpu_wr,
    input  logic             cpu_rd,
    input  logic [AW-1:0]    cpu_addr,
    input  logic [DW-1:0]    cpu_wdata,
    input  evt_t             sts,
    output logic [DW-1:0]    cpu_rdata,
    output logic [CNT_W-1:0] rep_cnt,
    output evt_t             ien,
    output logic             blk_en,
    output logic             cor_mode,
    output logic             start_req,
    output evt_t             clr
);

    logic pkt_mode_q;
    logic hit_ctrl, hit_rep, hit_ien, hit_ben, hit_cm, hit_sts;

    assign hit_ctrl = (cpu_addr == OFS_CTRL);
    assign hit_rep  = (cpu_addr == OFS_REPEAT);
    assign hit_ien  = (cpu_addr == OFS_IEN);
    assign hit_ben  = (cpu_addr == OFS_BEN);
    assign hit_cm   = (cpu_addr == OFS_CMODE);
    assign hit_sts  = (cpu_addr == OFS_STS);

    always_ff @(posedge clk) begin
        if (rst) begin
            pkt_mode_q <= 1'b0;
            rep_cnt    <= '0;
            ien        <= '0;
            blk_en     <= 1'b0;
            cor_mode   <= 1'b0;
        end else if (cpu_wr) begin
            if (hit_ctrl) pkt_mode_q <= cpu_wdata[PKT_BIT];
            if (hit_rep)  rep_cnt    <= cpu_wdata[CNT_W-1:0];
            if (hit_ien)  ien        <= unpack_pair(cpu_wdata);
            if (hit_ben)  blk_en     <= cpu_wdata[BEN_BIT];
            if (hit_cm)   cor_mode   <= cpu_wdata[COR_BIT];
        end
    end

    assign start_req = cpu_wr && hit_ctrl && !cpu_wdata[PKT_BIT];

    always_comb begin
        clr = '0;
        if (cor_mode) begin
            if (cpu_rd && hit_sts) clr = '{sot: 1'b1, eot: 1'b1};
        end else if (cpu_wr && hit_sts) begin
            clr = unpack_pair(cpu_wdata);
        end
    end

    always_comb begin
        cpu_rdata = '0;
        unique case (cpu_addr)
            OFS_CTRL:   cpu_rdata[PKT_BIT] = pkt_mode_q;
            OFS_REPEAT: cpu_rdata[CNT_W-1:0] = rep_cnt;
            OFS_IEN:    cpu_rdata = pack_pair(ien);
            OFS_BEN:    cpu_rdata[BEN_BIT] = blk_en;
            OFS_CMODE:  cpu_rdata[COR_BIT] = cor_mode;
            OFS_STS:    cpu_rdata = pack_pair(sts);
            default:    cpu_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dlk_txirq_seq.sv
module dlk_txirq_seq
    import dlk_txirq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_req,
    input  logic [CNT_W-1:0] rep_cnt,
    input  logic             msg_done,
    output logic             busy,
    output evt_t             evt
);

    logic [CNT_W-1:0] last_idx_q;
    logic [CNT_W-1:0] done_cnt_q;
    logic             accept;
    logic             final_done;

    assign accept     = start_req && !busy;
    assign final_done = busy && msg_done && (done_cnt_q == last_idx_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            last_idx_q <= '0;
            done_cnt_q <= '0;
        end else if (accept) begin
            busy       <= 1'b1;
            last_idx_q <= (rep_cnt == '0) ? '0 : rep_cnt - 1'b1;
            done_cnt_q <= '0;
        end else if (final_done) begin
            busy       <= 1'b0;
            done_cnt_q <= '0;
        end else if (busy && msg_done) begin
            done_cnt_q <= done_cnt_q + 1'b1;
        end
    end

    assign evt.sot = accept;
    assign evt.eot = final_done;

endmodule

// File: rtl/dlk_txirq_status.sv
module dlk_txirq_status
    import dlk_txirq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  evt_t evt,
    input  evt_t clr,
    input  evt_t ien,
    input  logic blk_en,
    output evt_t sts,
    output logic irq
);

    localparam int NSRC = 2;

    logic [NSRC-1:0] evt_v, clr_v, ien_v, sts_v;

    assign evt_v = {evt.sot, evt.eot};
    assign clr_v = {clr.sot, clr.eot};
    assign ien_v = {ien.sot, ien.eot};

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst) sts_v[i] <= 1'b0;
            else     sts_v[i] <= evt_v[i] | (sts_v[i] & ~clr_v[i]);
        end
    end

    assign sts.sot = sts_v[1];
    assign sts.eot = sts_v[0];
    assign irq     = blk_en & |(sts_v & ien_v);

endmodule

// File: rtl/dlk_txirq_ctrl.sv
module dlk_txirq_ctrl
    import dlk_txirq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cpu_wr,
    input  logic          cpu_rd,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    input  logic          msg_done,
    output logic          tx_start,
    output logic          tx_busy,
    output logic          irq
);

    logic [CNT_W-1:0] rep_cnt;
    evt_t             ien, clr, evt, sts;
    logic             blk_en, cor_mode, start_req;

    dlk_txirq_regs #(.CNT_W(CNT_W)) regs_i (
        .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .sts(sts),
        .cpu_rdata(cpu_rdata), .rep_cnt(rep_cnt), .ien(ien),
        .blk_en(blk_en), .cor_mode(cor_mode), .start_req(start_req),
        .clr(clr)
    );

    dlk_txirq_seq #(.CNT_W(CNT_W)) seq_i (
        .clk(clk), .rst(rst), .start_req(start_req), .rep_cnt(rep_cnt),
        .msg_done(msg_done), .busy(tx_busy), .evt(evt)
    );

    dlk_txirq_status status_i (
        .clk(clk), .rst(rst), .evt(evt), .clr(clr), .ien(ien),
        .blk_en(blk_en), .sts(sts), .irq(irq)
    );

    assign tx_start = evt.sot;

endmodule

// File: rtl/dlk_txirq_chk.sv
module dlk_txirq_chk
    import dlk_txirq_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          cpu_wr,
    input logic          cpu_rd,
    input logic [AW-1:0] cpu_addr,
    input logic [DW-1:0] cpu_wdata,
    input logic          tx_start,
    input logic          tx_busy,
    input logic          irq,
    input logic          blk_en,
    input logic          cor_mode,
    input evt_t          sts
);

    // R2
    start_sets_sot_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr == OFS_CTRL && !cpu_wdata[PKT_BIT] && !tx_busy)
        |=> (tx_busy && sts.sot));

    // R3
    end_sets_eot_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_busy) |-> sts.eot);

    // R4
    idle_no_eot_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_busy |=> !$rose(sts.eot));

    // R5
    busy_no_start_chk: assert property (@(posedge clk) disable iff (rst)
        tx_busy |-> !tx_start);

    // R7
    blk_mask_chk: assert property (@(posedge clk) disable iff (rst)
        !blk_en |-> !irq);

    // R6
    irq_needs_sts_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (sts.sot || sts.eot));

    // R8
    cor_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (cor_mode && cpu_rd && cpu_addr == OFS_STS && !tx_busy && !tx_start)
        |=> (!sts.sot && !sts.eot));

    // R10
    event_wins_chk: assert property (@(posedge clk) disable iff (rst)
        tx_start |=> sts.sot);

endmodule

bind dlk_txirq_ctrl dlk_txirq_chk chk_i (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .tx_start(tx_start),
    .tx_busy(tx_busy), .irq(irq), .blk_en(blk_en), .cor_mode(cor_mode),
    .sts(sts)
);

// File: tb/dlk_txirq_ctrl_tb_top.sv
module dlk_txirq_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       cpu_wr, cpu_rd, msg_done;
    logic [2:0] cpu_addr;
    logic [7:0] cpu_wdata;
    logic [7:0] cpu_rdata;
    logic       tx_start, tx_busy, irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit ended   = 1'b0;

    always #2.5 clk = ~clk;

    dlk_txirq_ctrl dut_i (
        .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .msg_done(msg_done), .tx_start(tx_start), .tx_busy(tx_busy), .irq(irq)
    );

    // vector: repeat count, per-bit enable, block enable, irq after start, irq after end
    typedef struct packed {
        logic [7:0] rep;
        logic [7:0] ien;
        logic [7:0] ben;
        logic       irq_s;
        logic       irq_e;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VT [NV] = '{
        '{8'd1, 8'h50, 8'h08, 1'b1, 1'b1},
        '{8'd3, 8'h40, 8'h08, 1'b1, 1'b0},
        '{8'd0, 8'h10, 8'h08, 1'b0, 1'b1},
        '{8'd5, 8'h50, 8'h00, 1'b0, 1'b0},
        '{8'd2, 8'h00, 8'h08, 1'b0, 1'b0},
        '{8'd4, 8'hFF, 8'hFF, 1'b1, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_rd = 1'b1; cpu_addr = a;
        #1 d = cpu_rdata;
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic done_pulse();
        @(negedge clk);
        msg_done = 1'b1;
        @(negedge clk);
        msg_done = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!ended) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int nm;
        rst = 1'b1; cpu_wr = 0; cpu_rd = 0; cpu_addr = 0; cpu_wdata = 0; msg_done = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), d);
            check("R1 reg", d, 8'h00);
        end
        check("R1 irq", irq, 1'b0);
        check("R1 busy", tx_busy, 1'b0);

        // R11 readback, masked
        wr(3'd1, 8'hA5); rd(3'd1, d); check("R11 repeat", d, 8'hA5);
        wr(3'd2, 8'hFF); rd(3'd2, d); check("R11 ien", d, 8'h50);
        wr(3'd3, 8'hFF); rd(3'd3, d); check("R11 ben", d, 8'h08);
        wr(3'd4, 8'hFF); rd(3'd4, d); check("R11 cmode", d, 8'h01);
        wr(3'd4, 8'h00);

        // R2 control write with packet bit 1 starts nothing
        wr(3'd0, 8'h01);
        check("R2 no start busy", tx_busy, 1'b0);
        rd(3'd5, d); check("R2 no start sts", d, 8'h00);
        rd(3'd0, d); check("R11 ctrl", d, 8'h01);

        // R4 done while idle
        done_pulse();
        rd(3'd5, d); check("R4 idle done sts", d, 8'h00);
        check("R4 idle done busy", tx_busy, 1'b0);

        // Table walk: R2 R3 R6 R7 R9
        for (int v = 0; v < NV; v++) begin
            wr(3'd1, VT[v].rep);
            wr(3'd2, VT[v].ien);
            wr(3'd3, VT[v].ben);
            @(negedge clk);
            cpu_wr = 1'b1; cpu_addr = 3'd0; cpu_wdata = 8'h00;
            #1 check("R2 tx_start pulse", tx_start, 1'b1);
            @(negedge clk);
            cpu_wr = 1'b0;
            check("R2 tx_start single", tx_start, 1'b0);
            check("R2 busy", tx_busy, 1'b1);
            rd(3'd5, d); check("R2 sot set", d, 8'h40);
            rd(3'd5, d); check("R9 read keeps", d, 8'h40);
            check("R6 irq start", irq, VT[v].irq_s);
            wr(3'd5, 8'h40);
            nm = (VT[v].rep == 0) ? 1 : int'(VT[v].rep);
            for (int k = 1; k <= nm; k++) begin
                done_pulse();
                if (k < nm) begin
                    check("R3 not yet busy", tx_busy, 1'b1);
                    rd(3'd5, d); check("R3 not yet sts", d, 8'h00);
                end
            end
            check("R3 busy drop", tx_busy, 1'b0);
            rd(3'd5, d); check("R3 eot set", d, 8'h10);
            check("R6 irq end", irq, VT[v].irq_e);
            wr(3'd5, 8'h10);
            rd(3'd5, d); check("R9 w1c eot", d, 8'h00);
        end

        // R7 block enable off masks both sources
        wr(3'd2, 8'h50); wr(3'd3, 8'h00); wr(3'd1, 8'd1);
        wr(3'd0, 8'h00); done_pulse();
        rd(3'd5, d); check("R7 both set", d, 8'h50);
        check("R7 irq masked", irq, 1'b0);
        wr(3'd3, 8'h08);
        check("R6 irq unmasked", irq, 1'b1);

        // R9 writing 0 leaves, writing one bit clears only it
        wr(3'd5, 8'h00); rd(3'd5, d); check("R9 zero write", d, 8'h50);
        wr(3'd5, 8'h40); rd(3'd5, d); check("R9 partial", d, 8'h10);
        wr(3'd5, 8'h10);

        // R5 start while busy ignored, R3 repeat change mid-transfer ignored
        wr(3'd1, 8'd3); wr(3'd0, 8'h00); wr(3'd5, 8'h40);
        wr(3'd1, 8'd1);
        wr(3'd0, 8'h00);
        rd(3'd5, d); check("R5 no sot", d, 8'h00);
        done_pulse();
        check("R5 still busy", tx_busy, 1'b1);
        done_pulse();
        check("R3 latched count busy", tx_busy, 1'b1);
        done_pulse();
        check("R5 end on orig count", tx_busy, 1'b0);
        rd(3'd5, d); check("R5 eot", d, 8'h10);
        wr(3'd5, 8'h10);

        // R8 clear-on-read, writes ignored
        wr(3'd4, 8'h01);
        wr(3'd1, 8'd1); wr(3'd0, 8'h00); done_pulse();
        wr(3'd5, 8'h50);
        rd(3'd5, d); check("R8 read value", d, 8'h50);
        rd(3'd5, d); check("R8 cleared", d, 8'h00);
        check("R8 irq low", irq, 1'b0);

        // R10 clearing read in same cycle as final done
        wr(3'd1, 8'd1); wr(3'd0, 8'h00);
        @(negedge clk);
        cpu_rd = 1'b1; cpu_addr = 3'd5; msg_done = 1'b1;
        #1 check("R10 pre-clear value", cpu_rdata, 8'h40);
        @(negedge clk);
        cpu_rd = 1'b0; msg_done = 1'b0;
        rd(3'd5, d); check("R10 eot survives", d, 8'h10);

        // R10 write-one-to-clear in same cycle as final done
        wr(3'd4, 8'h00);
        wr(3'd1, 8'd1); wr(3'd0, 8'h00);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = 3'd5; cpu_wdata = 8'h50; msg_done = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0; msg_done = 1'b0;
        rd(3'd5, d); check("R10 w1c collide", d, 8'h10);

        ended = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule